// File: doc/BRIEF.md
# Display Point Handshake Sequencer

This block moves one 3-D point at a time from a host into the converter stage of a vector display. A host ready strobe starts a transfer. The block captures the triplet in a first-stage register. On the next clock it copies that register into a second stage that drives the converters, so the converter inputs change once and never while the host bus is changing. The block then waits a settling interval for the beam deflectors and opens the intensity gate for a fixed number of cycles. Only after that does it send the host a one-cycle request for the next point.

A single window flag from an external comparator reports whether the point lies outside the visible volume. When it does, the beam stays dark and the request is sent at once. After a set number of host points the block emits a frame pulse. It then inserts one cursor slot, which loads the cursor triplet in place of host data, so the cursor appears once per frame. The request owed for the last host point of the frame is deferred until the cursor slot ends.

Every coordinate word is sign-magnitude. The top bit is the sign, and it selects the negative reference polarity for that axis.

Top module: `point_xfer_seq`

## Requirements
- R1: After reset, newPointReq, intensity, framePulse and cursorSel are low, and the three magnitudes and negRef are zero.
- R2: A transfer starts only when hostReady is high while the block is idle. A strobe that arrives during a transfer is ignored: it changes neither the output timing nor the loaded point.
- R3: The host triplet is captured into the first stage on the edge where hostReady is seen. The converter outputs keep their old value for the cycle that follows and take the new value one cycle later. They then hold it until the next copy.
- R4: On each axis, negRef is bit COORD_W-1 (the sign) of the word, and the magnitude output is bits COORD_W-2..0.
- R5: Intensity rises exactly SETTLE_CYC cycles after the second-stage copy. SETTLE_CYC is CLK_MHZ*SETTLE_NS/1000 and must be at least 2.
- R6: Intensity stays high for exactly PULSE_W cycles.
- R7: newPointReq is a single-cycle pulse. It is issued in the cycle in which intensity falls, once per host point.
- R8: winOut is sampled only in the cycle after the second-stage copy. When it is high there, no intensity is issued, and the request (or the frame pulse) follows in the next cycle.
- R9: At the end of every FRAME_PTS-th host point, a one-cycle framePulse is issued in place of the request.
- R10: After framePulse, cursorSel goes high. The cursor triplet passes through the same two stages, window check, settle and beam. The deferred request is issued when the slot ends, and cursorSel falls after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReady | input | 1 | Host strobe: a point is on hostX/Y/Z |
| hostX | input | COORD_W | Host X, sign-magnitude |
| hostY | input | COORD_W | Host Y, sign-magnitude |
| hostZ | input | COORD_W | Host Z, sign-magnitude |
| cursorX | input | COORD_W | Cursor X, sign-magnitude |
| cursorY | input | COORD_W | Cursor Y, sign-magnitude |
| cursorZ | input | COORD_W | Cursor Z, sign-magnitude |
| winOut | input | 1 | 1 = point lies outside the window |
| newPointReq | output | 1 | One-cycle request for the next host point |
| intensity | output | 1 | Beam intensity gate |
| framePulse | output | 1 | One-cycle frame marker |
| cursorSel | output | 1 | High during the cursor slot |
| magX | output | COORD_W-1 | X magnitude to converter |
| magY | output | COORD_W-1 | Y magnitude to converter |
| magZ | output | COORD_W-1 | Z magnitude to converter |
| negRef | output | 3 | Negative reference select per axis (bit 0 = X) |

## Verification
The assertions check on every cycle that:
- the second stage changes only on a copy strobe;
- the gate opens exactly the settle count after a copy and stays open exactly the pulse width;
- every beam end is followed at once by a request or a frame pulse;
- a request never lasts two cycles;
- a frame pulse always leads into a cursor slot.

Only the bench scenarios show the following behaviours:
- the window flag is sampled in exactly one cycle, shown by flag pulses placed just before and just inside that cycle;
- strobes during a busy transfer are dropped;
- sign and magnitude are split correctly;
- the request after the last point of a frame is deferred past the cursor slot.

// File: rtl/ptseq_pkg.sv
package ptseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_COPY,
    S_WCHK,
    S_SETTLE,
    S_BEAM,
    S_REQ,
    S_FRAME,
    S_CLOAD
  } ptseq_state_e;

  typedef struct packed {
    logic loadLow;
    logic selCursor;
    logic loadUp;
  } ptseq_strobe_t;

endpackage

// File: rtl/ptseq_datapath.sv
module ptseq_datapath
  import ptseq_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ptseq_strobe_t            strb,
  input  logic [2:0][COORD_W-1:0]  hostWord,
  input  logic [2:0][COORD_W-1:0]  curWord,
  output logic [2:0][COORD_W-1:0]  upperWord
);

  logic [2:0][COORD_W-1:0] lowerWord;

  for (genvar a = 0; a < 3; a++) begin : g_axis
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lowerWord[a] <= '0;
        upperWord[a] <= '0;
      end else begin
        if (strb.loadLow)
          lowerWord[a] <= strb.selCursor ? curWord[a] : hostWord[a];
        if (strb.loadUp)
          upperWord[a] <= lowerWord[a];
      end
    end
  end

  // R3
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadUp |=> $stable(upperWord));

  // R10
  cursor_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadLow && strb.selCursor) |=> (lowerWord == $past(curWord)));

endmodule

// File: rtl/ptseq_ctrl.sv
module ptseq_ctrl
  import ptseq_pkg::*;
#(
  parameter int SETTLE_CYC = 350,
  parameter int PULSE_W    = 16,
  parameter int FRAME_PTS  = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostReady,
  input  logic          winOut,
  output ptseq_strobe_t strb,
  output logic          newPointReq,
  output logic          intensity,
  output logic          framePulse,
  output logic          cursorSel
);

  localparam int MAX_CNT = (SETTLE_CYC > PULSE_W) ? SETTLE_CYC : PULSE_W;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int PT_W    = $clog2(FRAME_PTS + 1);
  localparam int CHK_W   = $clog2(MAX_CNT + 4) + 1;

  ptseq_state_e     state, nextState;
  logic [CNT_W-1:0] cnt;
  logic [PT_W-1:0]  ptCnt;
  logic             cursorSlot;
  logic             lastPt;
  logic             slotEnd;
  ptseq_state_e     endTarget;

  assign lastPt    = (ptCnt == PT_W'(FRAME_PTS - 1));
  assign endTarget = (!cursorSlot && lastPt) ? S_FRAME : S_REQ;
  assign slotEnd   = ((state == S_WCHK) && winOut) ||
                     ((state == S_BEAM) && (cnt == '0));

  always_comb begin
    strb = '0;
    unique case (state)
      S_IDLE:  strb.loadLow = hostReady;
      S_CLOAD: begin
        strb.loadLow   = 1'b1;
        strb.selCursor = 1'b1;
      end
      S_COPY:  strb.loadUp = 1'b1;
      default: strb = '0;
    endcase
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:   if (hostReady) nextState = S_COPY;
      S_COPY:   nextState = S_WCHK;
      S_WCHK:   nextState = winOut ? endTarget : S_SETTLE;
      S_SETTLE: if (cnt == '0) nextState = S_BEAM;
      S_BEAM:   if (cnt == '0) nextState = endTarget;
      S_REQ:    nextState = S_IDLE;
      S_FRAME:  nextState = S_CLOAD;
      S_CLOAD:  nextState = S_COPY;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      ptCnt      <= '0;
      cursorSlot <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_WCHK && !winOut)
        cnt <= CNT_W'(SETTLE_CYC - 2);
      else if (state == S_SETTLE && cnt == '0)
        cnt <= CNT_W'(PULSE_W - 1);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
      if (slotEnd && !cursorSlot)
        ptCnt <= lastPt ? '0 : ptCnt + 1'b1;
      if (state == S_FRAME)
        cursorSlot <= 1'b1;
      else if (state == S_REQ)
        cursorSlot <= 1'b0;
    end
  end

  assign newPointReq = (state == S_REQ);
  assign intensity   = (state == S_BEAM);
  assign framePulse  = (state == S_FRAME);
  assign cursorSel   = cursorSlot;

  logic [CHK_W-1:0] sinceUp;
  logic [CHK_W-1:0] beamLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceUp <= '0;
      beamLen <= '0;
    end else begin
      if (strb.loadUp)
        sinceUp <= CHK_W'(1);
      else if (sinceUp != '0 && sinceUp != '1)
        sinceUp <= sinceUp + 1'b1;
      beamLen <= intensity ? beamLen + 1'b1 : '0;
    end
  end

  // R5
  settle_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intensity) |-> (sinceUp == CHK_W'(SETTLE_CYC + 1)));

  // R6
  beam_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intensity) |-> (beamLen == CHK_W'(PULSE_W)));

  // R7
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    newPointReq |=> !newPointReq);

  // R7
  beam_end_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intensity) |-> (newPointReq || framePulse));

  // R9
  frame_cursor_chk: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |=> (cursorSel && !newPointReq));

endmodule

// File: rtl/point_xfer_seq.sv
module point_xfer_seq
  import ptseq_pkg::*;
#(
  parameter int COORD_W   = 10,
  parameter int CLK_MHZ   = 50,
  parameter int SETTLE_NS = 7000,
  parameter int PULSE_W   = 16,
  parameter int FRAME_PTS = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReady,
  input  logic [COORD_W-1:0] hostX,
  input  logic [COORD_W-1:0] hostY,
  input  logic [COORD_W-1:0] hostZ,
  input  logic [COORD_W-1:0] cursorX,
  input  logic [COORD_W-1:0] cursorY,
  input  logic [COORD_W-1:0] cursorZ,
  input  logic               winOut,
  output logic               newPointReq,
  output logic               intensity,
  output logic               framePulse,
  output logic               cursorSel,
  output logic [COORD_W-2:0] magX,
  output logic [COORD_W-2:0] magY,
  output logic [COORD_W-2:0] magZ,
  output logic [2:0]         negRef
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_NS / 1000;

  ptseq_strobe_t            strb;
  logic [2:0][COORD_W-1:0]  hostWord;
  logic [2:0][COORD_W-1:0]  curWord;
  logic [2:0][COORD_W-1:0]  upperWord;

  assign hostWord = {hostZ, hostY, hostX};
  assign curWord  = {cursorZ, cursorY, cursorX};

  ptseq_ctrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .PULSE_W    (PULSE_W),
    .FRAME_PTS  (FRAME_PTS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostReady   (hostReady),
    .winOut      (winOut),
    .strb        (strb),
    .newPointReq (newPointReq),
    .intensity   (intensity),
    .framePulse  (framePulse),
    .cursorSel   (cursorSel)
  );

  ptseq_datapath #(
    .COORD_W (COORD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hostWord  (hostWord),
    .curWord   (curWord),
    .upperWord (upperWord)
  );

  for (genvar a = 0; a < 3; a++) begin : g_sign
    assign negRef[a] = upperWord[a][COORD_W-1];
  end

  assign magX = upperWord[0][COORD_W-2:0];
  assign magY = upperWord[1][COORD_W-2:0];
  assign magZ = upperWord[2][COORD_W-2:0];

endmodule

// File: tb/point_xfer_seq_tb.sv
module point_xfer_seq_tb;

  localparam int W  = 10;
  localparam int S  = 8;
  localparam int P  = 4;
  localparam int FP = 3;
  localparam int NV = 9;
  localparam int LIM = 2 * (S + P) + 10;

  // vector: x[34:25] y[24:15] z[14:5] winMode[4:3] frameEnd[2] busy[1] spare[0]
  // winMode: 0 inside, 1 outside held, 2 outside only in sampled cycle, 3 outside only before it
  localparam logic [34:0] VEC [NV] = '{
    {10'h005, 10'h064, 10'h203, 2'd0, 1'b0, 1'b0, 1'b0},
    {10'h3FF, 10'h001, 10'h100, 2'd1, 1'b0, 1'b0, 1'b0},
    {10'h1AA, 10'h255, 10'h000, 2'd0, 1'b1, 1'b0, 1'b0},
    {10'h07F, 10'h280, 10'h011, 2'd2, 1'b0, 1'b0, 1'b0},
    {10'h200, 10'h0F0, 10'h3C3, 2'd3, 1'b0, 1'b0, 1'b0},
    {10'h123, 10'h045, 10'h267, 2'd1, 1'b1, 1'b0, 1'b0},
    {10'h0AB, 10'h2CD, 10'h0EF, 2'd0, 1'b0, 1'b1, 1'b0},
    {10'h301, 10'h102, 10'h003, 2'd0, 1'b0, 1'b0, 1'b0},
    {10'h055, 10'h0AA, 10'h2FF, 2'd2, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 0, rstN = 0, hostReady = 0, winOut = 0;
  logic [W-1:0] hostX = 0, hostY = 0, hostZ = 0;
  logic [W-1:0] cursorX = 10'h2A1, cursorY = 10'h0B2, cursorZ = 10'h1C3;
  logic newPointReq, intensity, framePulse, cursorSel;
  logic [W-2:0] magX, magY, magZ;
  logic [2:0] negRef;

  int nChecks = 0, nErr = 0;
  logic [W-1:0] prevX = 0, prevY = 0, prevZ = 0;

  always #5 clk = ~clk;

  point_xfer_seq #(.COORD_W(W), .CLK_MHZ(2), .SETTLE_NS(4000),
                   .PULSE_W(P), .FRAME_PTS(FP)) u_dut (
    .clk(clk), .rstN(rstN), .hostReady(hostReady),
    .hostX(hostX), .hostY(hostY), .hostZ(hostZ),
    .cursorX(cursorX), .cursorY(cursorY), .cursorZ(cursorZ),
    .winOut(winOut), .newPointReq(newPointReq), .intensity(intensity),
    .framePulse(framePulse), .cursorSel(cursorSel),
    .magX(magX), .magY(magY), .magZ(magZ), .negRef(negRef));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int packOut();
    return {negRef, magZ, magY, magX};
  endfunction

  function automatic int packExp(input logic [W-1:0] x, y, z);
    return {z[W-1], y[W-1], x[W-1], z[W-2:0], y[W-2:0], x[W-2:0]};
  endfunction

  task automatic runPoint(input logic [34:0] v);
    logic [W-1:0] px, py, pz;
    logic [1:0] mode;
    logic fe, busy, isOut;
    int intFirst, intCnt, reqCnt, reqIdx, frCnt, frIdx, curCnt, c, endIdx;
    px = v[34:25]; py = v[24:15]; pz = v[14:5];
    mode = v[4:3]; fe = v[2]; busy = v[1];
    isOut = (mode == 2'd1) || (mode == 2'd2);
    intFirst = -1; intCnt = 0; reqCnt = 0; reqIdx = -1;
    frCnt = 0; frIdx = -1; curCnt = 0;
    endIdx = isOut ? 2 : S + P + 1;
    c = endIdx + 2;
    hostX = px; hostY = py; hostZ = pz;
    winOut = (mode == 2'd1);
    @(negedge clk) hostReady = 1;
    @(negedge clk) hostReady = 0;
    // R3: converters still show previous point one cycle after capture
    chk(packOut() == packExp(prevX, prevY, prevZ), "R3 old value held",
        packOut(), packExp(prevX, prevY, prevZ));
    for (int k = 0; k < LIM; k++) begin
      if (k > 0) @(negedge clk);
      if (intensity) begin
        if (intFirst < 0) intFirst = k;
        intCnt++;
      end
      if (newPointReq) begin reqCnt++; reqIdx = k; end
      if (framePulse) begin frCnt++; frIdx = k; end
      if (cursorSel) curCnt++;
      if (k == 1)
        // R4: sign bit to negRef, remaining bits to magnitude
        chk(packOut() == packExp(px, py, pz), "R4 sign/magnitude split",
            packOut(), packExp(px, py, pz));
      if (fe && k == c + 1)
        chk(packOut() == packExp(cursorX, cursorY, cursorZ), "R10 cursor loaded",
            packOut(), packExp(cursorX, cursorY, cursorZ));
      if (k == 0 && mode == 2'd3) winOut = 1;
      if (k == 1) winOut = (mode == 2'd2) || (mode == 2'd1);
      if (k == 2) winOut = 0;
      if (busy && k == 4) begin
        hostReady = 1; hostX = 10'h3FF; hostY = 10'h3FF; hostZ = 10'h3FF;
      end
      if (busy && k == 5) hostReady = 0;
    end
    if (!fe) begin
      chk(intCnt == (isOut ? 0 : P), "R6/R8 beam cycles", intCnt, isOut ? 0 : P);
      if (!isOut) chk(intFirst == S + 1, "R5 settle delay", intFirst, S + 1);
      chk(reqCnt == 1, "R7 one request", reqCnt, 1);
      chk(reqIdx == endIdx, "R7/R8 request timing", reqIdx, endIdx);
      chk(frCnt == 0, "R9 no frame mid-frame", frCnt, 0);
      chk(packOut() == packExp(px, py, pz), "R2/R3 point held", packOut(),
          packExp(px, py, pz));
      prevX = px; prevY = py; prevZ = pz;
    end else begin
      chk(frCnt == 1, "R9 one frame pulse", frCnt, 1);
      chk(frIdx == endIdx, "R9 frame pulse timing", frIdx, endIdx);
      chk(intCnt == (isOut ? P : 2 * P), "R10 beam cycles", intCnt, isOut ? P : 2 * P);
      chk(intFirst == (isOut ? c + S + 1 : S + 1), "R5/R10 first beam", intFirst,
          isOut ? c + S + 1 : S + 1);
      chk(reqCnt == 1, "R10 deferred request count", reqCnt, 1);
      chk(reqIdx == c + S + P + 1, "R10 deferred request timing", reqIdx, c + S + P + 1);
      chk(curCnt == S + P + 3, "R10 cursor slot length", curCnt, S + P + 3);
      prevX = cursorX; prevY = cursorY; prevZ = cursorZ;
    end
  endtask

  initial begin
    #(10 * 100000);
    nErr++;
    $display("FAIL R1 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk({newPointReq, intensity, framePulse, cursorSel} == 4'b0, "R1 controls low",
        int'({newPointReq, intensity, framePulse, cursorSel}), 0);
    chk(packOut() == 0, "R1 converter outputs zero", packOut(), 0);
    // R2: no activity without hostReady
    begin
      int act = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (newPointReq || intensity || framePulse || cursorSel) act++;
      end
      chk(act == 0, "R2 idle without strobe", act, 0);
    end
    for (int i = 0; i < NV; i++) runPoint(VEC[i]);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule